// File: doc/BRIEF.md
# Tagged Byte FIFO with Run-Length Expansion on Host Reads

This block buffers bytes on the data path of an extended-capability parallel port. Each slot holds a data byte and a tag bit. There are two ways to load it. The host writes bytes, and these are always stored with the tag high. The peripheral side pushes bytes and supplies its own tag with each one. The block drives registered full and empty flags. A synchronous clear drops all stored bytes at once, for example when the port changes mode.

When the host reads, the block expands run-length encoded data. A stored slot whose tag is low and whose data bit 7 is also low is a repeat count. The host never sees that slot. Its low seven bits, N, give the number of extra copies of the byte that follows it: the host gets that byte N+1 times, and only then does the FIFO move past it. A read finds nothing to return in two cases: the FIFO is empty, or a count has been taken but its byte has not yet arrived. In both cases the read returns the last byte already delivered, and the empty flag still reflects the real occupancy.

Top module: `ecp_rle_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `host_rd_data` is 0x00.
- R2: A host write stores its byte with tag 1. A host-written byte is therefore returned literally, even when its bit 7 is 0.
- R3: A peripheral push stores the supplied tag bit. A slot with tag 1, or with data bit 7 equal to 1, is returned literally. Slots are returned in the order they were stored.
- R4: A write from either source while `full` is 1 is discarded. The bytes already stored and their order are unchanged.
- R5: A slot with tag 0 and data bit 7 equal to 0 is a count N, taken from data bits 6:0. It is never returned. The slot after it is returned N+1 times and then removed. With N = 0 the byte is returned once.
- R6: `host_rd_data` is registered. It changes only in the cycle after `host_rd_en` is high. The first read after a count already returns the repeated byte.
- R7: A read with nothing to deliver returns the last byte delivered. An empty FIFO stays empty after such a read.
- R8: A count slot read while no byte follows it is consumed. The expansion stays pending, and the next byte that arrives is returned N+1 times.
- R9: A high `clr` empties the FIFO and cancels any pending or active expansion. In the next cycle `empty` is 1 and `full` is 0.
- R10: A host write and a peripheral push in the same cycle store only the host byte. The pushed byte is dropped.
- R11: `full` and `empty` are registered and track occupancy from the cycle after each write, read or clear. They are never both 1. The depth is a parameter, 16 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of contents and expansion state |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 8 | Host write byte, stored with tag 1 |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_data | output | 8 | Registered read byte, valid the cycle after the strobe |
| per_push | input | 1 | Peripheral-side push strobe |
| per_push_data | input | 8 | Peripheral-side byte |
| per_push_tag | input | 1 | Tag stored with the peripheral-side byte |
| full | output | 1 | Registered full flag |
| empty | output | 1 | Registered empty flag |

## Verification
Some properties are checked on every cycle: the flags are never both set; a full FIFO stays full until it is read; a read of an empty FIFO and an idle cycle both leave the output byte unchanged; a clear leaves the FIFO empty with no expansion running. Only the bench's scenarios can show which byte comes out of a read. That covers the exact repeat count after a count slot, the silent consumption of that slot, and a run that waits for its byte to arrive. It also covers which source wins a simultaneous write and the literal handling of tagged or high-bit bytes.

// File: rtl/ecp_fifo_pkg.sv
package ecp_fifo_pkg;
  localparam int BYTE_W = 8;
  localparam int RUN_W  = BYTE_W - 1;

  typedef struct packed {
    logic              tag;
    logic [BYTE_W-1:0] data;
  } fifo_entry_t;
endpackage

// File: rtl/ecp_fifo_store.sv
module ecp_fifo_store
  import ecp_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  fifo_entry_t      push_entry,
  input  logic [1:0]       pop_cnt,
  output fifo_entry_t      head,
  output fifo_entry_t      next_e,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  fifo_entry_t      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] lvl_nxt;
  logic             do_push;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return s[PTR_W-1:0];
  endfunction

  assign do_push = push && !full;
  assign lvl_nxt = level + LVL_W'(do_push) - LVL_W'(pop_cnt);

  // storage array without reset so it maps onto memory resources
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (do_push) wr_ptr <= adv(wr_ptr, 1);
      rd_ptr <= adv(rd_ptr, int'(pop_cnt));
      level  <= lvl_nxt;
      full   <= (lvl_nxt == LVL_W'(DEPTH));
      empty  <= (lvl_nxt == '0);
    end
  end

  assign head   = mem[rd_ptr];
  assign next_e = mem[adv(rd_ptr, 1)];
endmodule

// File: rtl/ecp_rle_reader.sv
module ecp_rle_reader
  import ecp_fifo_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rd_en,
  input  fifo_entry_t       head,
  input  fifo_entry_t       next_e,
  input  logic [LVL_W-1:0]  level,
  output logic [1:0]        pop_cnt,
  output logic [BYTE_W-1:0] rd_data,
  output logic              run_active,
  output logic [RUN_W-1:0]  run_cnt
);
  logic [BYTE_W-1:0] data_nxt;
  logic              act_nxt;
  logic [RUN_W-1:0]  cnt_nxt;
  logic              have_one, have_two, is_count;

  assign have_one = (level != '0);
  assign have_two = (level >= LVL_W'(2));
  assign is_count = !head.tag && !head.data[BYTE_W-1];

  always_comb begin
    pop_cnt  = 2'd0;
    data_nxt = rd_data;
    act_nxt  = run_active;
    cnt_nxt  = run_cnt;
    if (rd_en && have_one) begin
      if (run_active) begin
        data_nxt = head.data;
        if (run_cnt == '0) begin
          pop_cnt = 2'd1;
          act_nxt = 1'b0;
        end else begin
          cnt_nxt = run_cnt - 1'b1;
        end
      end else if (is_count) begin
        if (have_two) begin
          data_nxt = next_e.data;
          if (head.data[RUN_W-1:0] == '0) begin
            pop_cnt = 2'd2;
          end else begin
            pop_cnt = 2'd1;
            act_nxt = 1'b1;
            cnt_nxt = head.data[RUN_W-1:0] - 1'b1;
          end
        end else begin
          pop_cnt = 2'd1;
          act_nxt = 1'b1;
          cnt_nxt = head.data[RUN_W-1:0];
        end
      end else begin
        data_nxt = head.data;
        pop_cnt  = 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      run_active <= 1'b0;
      run_cnt    <= '0;
    end else begin
      rd_data <= data_nxt;
      if (clr) begin
        run_active <= 1'b0;
        run_cnt    <= '0;
      end else begin
        run_active <= act_nxt;
        run_cnt    <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/ecp_rle_fifo.sv
module ecp_rle_fifo
  import ecp_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       host_wr_en,
  input  logic [7:0] host_wr_data,
  input  logic       host_rd_en,
  output logic [7:0] host_rd_data,
  input  logic       per_push,
  input  logic [7:0] per_push_data,
  input  logic       per_push_tag,
  output logic       full,
  output logic       empty
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  fifo_entry_t      wr_entry, head, next_e;
  logic             push;
  logic [1:0]       pop_cnt;
  logic [LVL_W-1:0] level;
  logic             run_active;
  logic [RUN_W-1:0] run_cnt;

  // host side takes the slot when both sources write together
  assign push     = host_wr_en || per_push;
  assign wr_entry = host_wr_en ? '{tag: 1'b1, data: host_wr_data}
                               : '{tag: per_push_tag, data: per_push_data};

  ecp_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .clr(clr),
    .push(push), .push_entry(wr_entry), .pop_cnt(pop_cnt),
    .head(head), .next_e(next_e), .level(level),
    .full(full), .empty(empty)
  );

  ecp_rle_reader #(.LVL_W(LVL_W)) u_reader (
    .clk(clk), .rst(rst), .clr(clr), .rd_en(host_rd_en),
    .head(head), .next_e(next_e), .level(level),
    .pop_cnt(pop_cnt), .rd_data(host_rd_data),
    .run_active(run_active), .run_cnt(run_cnt)
  );
endmodule

// File: rtl/ecp_rle_fifo_chk.sv
module ecp_rle_fifo_chk (
  input logic       clk,
  input logic       rst,
  input logic       clr,
  input logic       host_wr_en,
  input logic       per_push,
  input logic       host_rd_en,
  input logic [7:0] host_rd_data,
  input logic       full,
  input logic       empty,
  input logic       run_active
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R11

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (full && !host_rd_en && !clr) |=> full); // R4

  AST_UNDERRUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && empty) |=> $stable(host_rd_data)); // R7

  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst)
    (empty && !host_wr_en && !per_push) |=> empty); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !host_rd_en |=> $stable(host_rd_data)); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (empty && !full && !run_active)); // R9
endmodule

bind ecp_rle_fifo ecp_rle_fifo_chk u_chk (
  .clk(clk), .rst(rst), .clr(clr), .host_wr_en(host_wr_en),
  .per_push(per_push), .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
  .full(full), .empty(empty), .run_active(run_active)
);

// File: tb/ecp_rle_fifo_test.sv
module ecp_rle_fifo_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       host_wr_en = 1'b0;
  logic [7:0] host_wr_data = '0;
  logic       host_rd_en = 1'b0;
  logic [7:0] host_rd_data;
  logic       per_push = 1'b0;
  logic [7:0] per_push_data = '0;
  logic       per_push_tag = 1'b0;
  logic       full, empty;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecp_rle_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .clr(clr),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .per_push(per_push), .per_push_data(per_push_data), .per_push_tag(per_push_tag),
    .full(full), .empty(empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); host_wr_en = 1'b1; host_wr_data = d;
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic per_write(input logic tag, input logic [7:0] d);
    @(negedge clk); per_push = 1'b1; per_push_tag = tag; per_push_data = d;
    @(negedge clk); per_push = 1'b0;
  endtask

  task automatic read_expect(input logic [7:0] exp, input string req);
    @(negedge clk); host_rd_en = 1'b1;
    @(negedge clk); host_rd_en = 1'b0;
    check(host_rd_data == exp, req, host_rd_data, exp);
  endtask

  task automatic flags_expect(input bit e, input bit f, input string req);
    check(empty == e && full == f, req, {empty, full}, {e, f});
  endtask

  task automatic t_reset;
    flags_expect(1'b1, 1'b0, "R1 flags");
    check(host_rd_data == 8'h00, "R1 data", host_rd_data, 0);
  endtask

  task automatic t_host_literal;
    host_write(8'hA5);
    host_write(8'h03);
    flags_expect(1'b0, 1'b0, "R11 not empty after write");
    read_expect(8'hA5, "R2 first byte");
    read_expect(8'h03, "R2 low-bit7 host byte literal");
    flags_expect(1'b1, 1'b0, "R11 empty after drain");
  endtask

  task automatic t_per_literal;
    per_write(1'b1, 8'h41);
    per_write(1'b0, 8'h85);
    read_expect(8'h41, "R3 tagged push");
    read_expect(8'h85, "R3 untagged bit7 set literal");
    flags_expect(1'b1, 1'b0, "R3 drained");
  endtask

  task automatic t_rle_basic;
    per_write(1'b0, 8'h03);
    per_write(1'b1, 8'h77);
    host_write(8'h12);
    read_expect(8'h77, "R6 first read after count gives repeat");
    for (int i = 0; i < 3; i++) read_expect(8'h77, "R5 repeated byte");
    read_expect(8'h12, "R5 advance after N+1");
    flags_expect(1'b1, 1'b0, "R5 empty after run");
  endtask

  task automatic t_rle_zero;
    per_write(1'b0, 8'h00);
    host_write(8'h55);
    read_expect(8'h55, "R5 count zero once");
    flags_expect(1'b1, 1'b0, "R5 count zero consumes both");
  endtask

  task automatic t_underrun;
    read_expect(8'h55, "R7 underrun returns last");
    flags_expect(1'b1, 1'b0, "R7 still empty");
    repeat (2) @(negedge clk);
    check(host_rd_data == 8'h55, "R6 idle hold", host_rd_data, 8'h55);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) host_write(8'h30 + 8'(i));
    flags_expect(1'b0, 1'b1, "R11 full at depth");
    host_write(8'hEE);
    per_write(1'b1, 8'hDD);
    flags_expect(1'b0, 1'b1, "R4 still full");
    for (int i = 0; i < DEPTH; i++) read_expect(8'h30 + 8'(i), "R4 order kept");
    flags_expect(1'b1, 1'b0, "R4 dropped bytes absent");
    read_expect(8'h3F, "R7 underrun after full drain");
  endtask

  task automatic t_pending;
    per_write(1'b0, 8'h01);
    read_expect(8'h3F, "R8 count alone returns last");
    flags_expect(1'b1, 1'b0, "R8 count consumed");
    host_write(8'h66);
    read_expect(8'h66, "R8 pending run first");
    read_expect(8'h66, "R8 pending run second");
    flags_expect(1'b1, 1'b0, "R8 run done");
    read_expect(8'h66, "R7 underrun after run");
  endtask

  task automatic t_clear;
    per_write(1'b0, 8'h05);
    per_write(1'b1, 8'h99);
    host_write(8'h11);
    read_expect(8'h99, "R9 run started");
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    flags_expect(1'b1, 1'b0, "R9 clear empties");
    host_write(8'h21);
    host_write(8'h22);
    read_expect(8'h21, "R9 run cancelled");
    read_expect(8'h22, "R9 next literal");
  endtask

  task automatic t_collide;
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_data = 8'h10;
    per_push = 1'b1; per_push_tag = 1'b1; per_push_data = 8'h20;
    @(negedge clk);
    host_wr_en = 1'b0; per_push = 1'b0;
    read_expect(8'h10, "R10 host wins");
    flags_expect(1'b1, 1'b0, "R10 push dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_host_literal();
    t_per_literal();
    t_rle_basic();
    t_rle_zero();
    t_underrun();
    t_full();
    t_pending();
    t_clear();
    t_collide();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=0x1 expected=0x0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule